// File: doc/BRIEF.md
# Prescaled Input Period Counter Array

This block measures how long a chosen input stays between two consecutive active transitions. Time is counted in units of a programmable prescaler. The block holds several independent measurement channels. Each channel has its own enable, one-shot or continuous mode, edge polarity, input selection and prescale setting, and each one reports its latest result on its own output slice.

A channel is armed when its enable goes from low to high. It then waits for the first active transition on its selected input (the opening edge) and counts prescaler ticks until the next active transition (the closing edge). At the closing edge it copies the count to its result output and raises a one-cycle valid pulse.

In one-shot mode the channel also pulses `enableClear` so that the owning register can drop the enable bit, and the channel goes idle. In continuous mode the closing edge also opens the next measurement. Register decoding and input synchronisation sit outside this block.

Top module: `period_meter_array`

## Requirements
- R1: After reset every channel is idle, with `periodValid`, `enableClear` and every `periodValue` slice at zero.
- R2: With `cfgPolarity` = 1 the active transition is the selected input going 0 to 1. With `cfgPolarity` = 0 it is the input going 1 to 0. Transitions of the other direction are ignored.
- R3: A channel arms only on a 0-to-1 change of its `cfgEnable`. After a one-shot measurement it stays idle while `cfgEnable` remains high, and further input edges produce no result.
- R4: With prescale value P, and N clock cycles between the opening and closing active transitions at the input, the result is floor(N / (P + 1)).
- R5: With prescale value 0, the result equals N, the number of clock cycles between the two active transitions.
- R6: In one-shot mode (`cfgContinuous` = 0), `enableClear` for that channel is high for exactly one cycle, in the same cycle as its `periodValid` pulse.
- R7: In continuous mode every active transition after the opening one produces a new result, which measures the gap since the previous active transition. `enableClear` is never raised in this mode.
- R8: Dropping `cfgEnable` in the middle of a measurement abandons it. No result is produced, and the previous `periodValue` is kept.
- R9: The period count saturates at all ones (2^CNT_W - 1) and does not wrap.
- R10: `periodValid` is a one-cycle pulse per completed measurement, and `periodValue` keeps its value until the next completed measurement.
- R11: Channels are independent. Channel i watches `sigIn[cfgSelect slice i]` and uses only its own configuration slice. Slice i of a flattened bus occupies bits [i*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | NUM_IN | Already synchronised candidate inputs |
| cfgEnable | input | NUM_CH | Per-channel enable level |
| cfgContinuous | input | NUM_CH | 1 = continuous, 0 = one-shot |
| cfgPolarity | input | NUM_CH | 1 = rising active, 0 = falling active |
| cfgSelect | input | NUM_CH*SEL_W | Per-channel input index |
| cfgPrescale | input | NUM_CH*PRE_W | Per-channel prescale value P |
| enableClear | output | NUM_CH | One-cycle request to clear the enable bit |
| periodValid | output | NUM_CH | One-cycle pulse marking a new result |
| periodValue | output | NUM_CH*CNT_W | Latest measured period per channel |

## Verification
Two situations are hard to reach from the ports. The first is saturation: at the default counter width it needs billions of cycles. The bench therefore builds the block with an 8-bit counter and spaces two edges 300 cycles apart. The second is the idle state that follows a one-shot measurement while the enable is still high. The bench reaches it by leaving the enable asserted after the result and then driving further active transitions. Gaps between transitions are chosen so that the floor division of R4 gives distinct answers for several prescale values.

// File: rtl/pmeter_pkg.sv
package pmeter_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_OPEN  = 2'd1,
    ST_CLOSE = 2'd2
  } meterState_t;

  typedef struct packed {
    logic clearCnt;
    logic incCnt;
    logic capture;
  } meterStrobe_t;

endpackage

// File: rtl/pmeter_ctrl.sv
module pmeter_ctrl
  import pmeter_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int SEL_W  = 5,
  parameter int PRE_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  sigIn,
  input  logic               enable,
  input  logic               continuous,
  input  logic               polarity,
  input  logic [SEL_W-1:0]   select,
  input  logic [PRE_W-1:0]   prescale,
  output meterStrobe_t       strobe,
  output logic               enableClear
);

  meterState_t state;
  logic sNow, sPrev, enPrev;
  logic [PRE_W-1:0] preCnt;
  logic selBit, activeEdge, tick, inClose;

  // input pick; an index past the input count reads as zero
  always_comb begin
    selBit = 1'b0;
    for (int k = 0; k < NUM_IN; k++) begin
      if (select == SEL_W'(k)) selBit = sigIn[k];
    end
  end

  assign activeEdge = polarity ? (~sPrev & sNow) : (sPrev & ~sNow);
  assign inClose    = (state == ST_CLOSE) && enable;
  assign tick       = inClose && (preCnt >= prescale);

  always_comb begin
    strobe.capture  = inClose && activeEdge;
    strobe.incCnt   = tick;
    strobe.clearCnt = !inClose;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sNow        <= 1'b0;
      sPrev       <= 1'b0;
      enPrev      <= 1'b0;
      state       <= ST_OFF;
      preCnt      <= '0;
      enableClear <= 1'b0;
    end else begin
      sNow        <= selBit;
      sPrev       <= sNow;
      enPrev      <= enable;
      enableClear <= 1'b0;
      if (!enable) begin
        state <= ST_OFF;
      end else begin
        unique case (state)
          ST_OFF:   if (!enPrev) state <= ST_OPEN;
          ST_OPEN:  if (activeEdge) state <= ST_CLOSE;
          ST_CLOSE: if (activeEdge && !continuous) begin
                      state       <= ST_OFF;
                      enableClear <= 1'b1;
                    end
          default:  state <= ST_OFF;
        endcase
      end
      // prescaler restarts at every opening and closing edge
      if (inClose && !activeEdge) preCnt <= tick ? '0 : preCnt + 1'b1;
      else                        preCnt <= '0;
    end
  end

  p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> state == ST_OFF);

  p_clear_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    enableClear |=> !enableClear);

  p_clear_after_oneshot_r6: assert property (@(posedge clk) disable iff (!rstN)
    enableClear |-> ($past(state) == ST_CLOSE) && !$past(continuous));

  p_no_rearm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && enPrev && enable) |=> state == ST_OFF);

  p_no_clear_cont_r7: assert property (@(posedge clk) disable iff (!rstN)
    (continuous && $past(continuous)) |-> !enableClear);

endmodule

// File: rtl/pmeter_datapath.sv
module pmeter_datapath
  import pmeter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  meterStrobe_t     strobe,
  output logic [CNT_W-1:0] periodValue,
  output logic             periodValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] satNext;

  assign sum     = {1'b0, cnt} + (CNT_W+1)'(strobe.incCnt);
  assign satNext = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      periodValue <= '0;
      periodValid <= 1'b0;
    end else begin
      periodValid <= strobe.capture;
      if (strobe.capture) begin
        periodValue <= satNext;
        cnt         <= '0;
      end else if (strobe.clearCnt) begin
        cnt <= '0;
      end else begin
        cnt <= satNext;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(periodValue));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    periodValid |=> !periodValid);

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !strobe.clearCnt && !strobe.capture) |=> cnt == CNT_MAX);

endmodule

// File: rtl/period_meter_array.sv
module period_meter_array
  import pmeter_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_IN = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IN-1:0]         sigIn,
  input  logic [NUM_CH-1:0]         cfgEnable,
  input  logic [NUM_CH-1:0]         cfgContinuous,
  input  logic [NUM_CH-1:0]         cfgPolarity,
  input  logic [NUM_CH*SEL_W-1:0]   cfgSelect,
  input  logic [NUM_CH*PRE_W-1:0]   cfgPrescale,
  output logic [NUM_CH-1:0]         enableClear,
  output logic [NUM_CH-1:0]         periodValid,
  output logic [NUM_CH*CNT_W-1:0]   periodValue
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    meterStrobe_t strobe;

    pmeter_ctrl #(.NUM_IN(NUM_IN), .SEL_W(SEL_W), .PRE_W(PRE_W)) u_ctrl (
      .clk         (clk),
      .rstN        (rstN),
      .sigIn       (sigIn),
      .enable      (cfgEnable[i]),
      .continuous  (cfgContinuous[i]),
      .polarity    (cfgPolarity[i]),
      .select      (cfgSelect[i*SEL_W +: SEL_W]),
      .prescale    (cfgPrescale[i*PRE_W +: PRE_W]),
      .strobe      (strobe),
      .enableClear (enableClear[i])
    );

    pmeter_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk         (clk),
      .rstN        (rstN),
      .strobe      (strobe),
      .periodValue (periodValue[i*CNT_W +: CNT_W]),
      .periodValid (periodValid[i])
    );

    p_clear_with_result_r6: assert property (@(posedge clk) disable iff (!rstN)
      enableClear[i] |-> periodValid[i]);
  end

endmodule

// File: tb/period_meter_array_test.sv
module period_meter_array_test;

  localparam int CH   = 2;
  localparam int NIN  = 4;
  localparam int CW   = 8;
  localparam int PW   = 4;
  localparam int SW   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NIN-1:0]   sigIn = '0;
  logic [CH-1:0]    en = '0, cont = '0, pol = '0;
  logic [CH*SW-1:0] sel = '0;
  logic [CH*PW-1:0] pre = '0;
  logic [CH-1:0]    enableClear, periodValid;
  logic [CH*CW-1:0] periodValue;

  int testsRun = 0;
  int testsFailed = 0;
  int validCnt [CH];
  int clrCnt   [CH];
  int lastVal  [CH];

  always #2.5 clk = ~clk;

  period_meter_array #(.NUM_CH(CH), .NUM_IN(NIN), .CNT_W(CW), .PRE_W(PW)) uut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .cfgEnable(en), .cfgContinuous(cont),
    .cfgPolarity(pol), .cfgSelect(sel), .cfgPrescale(pre),
    .enableClear(enableClear), .periodValid(periodValid), .periodValue(periodValue)
  );

  initial begin
    for (int c = 0; c < CH; c++) begin validCnt[c] = 0; clrCnt[c] = 0; lastVal[c] = 0; end
  end

  // monitor of output pulses, sampled away from the active edge
  always @(negedge clk) begin
    for (int c = 0; c < CH; c++) begin
      if (periodValid[c]) begin
        validCnt[c] = validCnt[c] + 1;
        lastVal[c]  = int'(periodValue[c*CW +: CW]);
      end
      if (enableClear[c]) clrCnt[c] = clrCnt[c] + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ch, input bit c, input bit p, input int s, input int ps);
    en[ch] = 1'b0;
    cont[ch] = c;
    pol[ch] = p;
    sel[ch*SW +: SW] = SW'(s);
    pre[ch*PW +: PW] = PW'(ps);
    cyc(2);
    en[ch] = 1'b1;
    cyc(3);
  endtask

  task automatic t_reset;
    chk("R1 valid", int'(periodValid), 0);
    chk("R1 clear", int'(enableClear), 0);
    chk("R1 value", int'(periodValue), 0);
  endtask

  task automatic t_oneshot;
    int v0, c0;
    setup(0, 0, 1, 0, 0);
    v0 = validCnt[0]; c0 = clrCnt[0];
    sigIn[0] = 1; cyc(10); sigIn[0] = 0; cyc(7); sigIn[0] = 1; cyc(6);
    chk("R5 period", lastVal[0], 17);
    chk("R10 one pulse", validCnt[0] - v0, 1);
    chk("R6 clear pulse", clrCnt[0] - c0, 1);
    // enable left high: no rearm
    v0 = validCnt[0];
    sigIn[0] = 0; cyc(4); sigIn[0] = 1; cyc(5); sigIn[0] = 0; cyc(4); sigIn[0] = 1; cyc(8);
    chk("R3 no rearm", validCnt[0] - v0, 0);
    en[0] = 0; cyc(20);
    chk("R10 hold", int'(periodValue[0 +: CW]), 17);
  endtask

  task automatic t_prescale;
    sigIn[0] = 0;
    setup(0, 0, 1, 0, 3);
    sigIn[0] = 1; cyc(11); sigIn[0] = 0; cyc(11); sigIn[0] = 1; cyc(6);
    chk("R4 P=3 N=22", lastVal[0], 5);
    en[0] = 0;
    sigIn[0] = 0;
    setup(0, 0, 1, 0, 1);
    sigIn[0] = 1; cyc(4); sigIn[0] = 0; cyc(5); sigIn[0] = 1; cyc(6);
    chk("R4 P=1 N=9", lastVal[0], 4);
    en[0] = 0;
  endtask

  task automatic t_falling;
    sigIn[0] = 1;
    setup(0, 0, 0, 0, 0);
    sigIn[0] = 0; cyc(5); sigIn[0] = 1; cyc(6); sigIn[0] = 0; cyc(6);
    chk("R2 falling", lastVal[0], 11);
    en[0] = 0;
  endtask

  task automatic t_continuous;
    int v0, c0;
    sigIn[0] = 0;
    setup(0, 1, 1, 0, 0);
    v0 = validCnt[0]; c0 = clrCnt[0];
    sigIn[0] = 1; cyc(4); sigIn[0] = 0; cyc(4);
    sigIn[0] = 1; cyc(5);
    chk("R7 first gap", lastVal[0], 8);
    sigIn[0] = 0; cyc(7);
    sigIn[0] = 1; cyc(3);
    sigIn[0] = 0; cyc(3);
    chk("R7 second gap", lastVal[0], 12);
    sigIn[0] = 1; cyc(6);
    chk("R7 third gap", lastVal[0], 6);
    chk("R7 count", validCnt[0] - v0, 3);
    chk("R7 no clear", clrCnt[0] - c0, 0);
    en[0] = 0; cyc(2);
  endtask

  task automatic t_abort;
    int v0;
    sigIn[0] = 0;
    setup(0, 0, 1, 0, 0);
    v0 = validCnt[0];
    sigIn[0] = 1; cyc(5); en[0] = 0; cyc(3); sigIn[0] = 0; cyc(3); sigIn[0] = 1; cyc(8);
    chk("R8 no result", validCnt[0] - v0, 0);
    chk("R8 value kept", int'(periodValue[0 +: CW]), 6);
  endtask

  task automatic t_saturate;
    sigIn[0] = 0;
    setup(0, 0, 1, 0, 0);
    sigIn[0] = 1; cyc(150); sigIn[0] = 0; cyc(150); sigIn[0] = 1; cyc(6);
    chk("R9 saturate", lastVal[0], 255);
    en[0] = 0;
  endtask

  task automatic t_indep;
    int v0;
    sigIn = '0;
    setup(0, 0, 1, 1, 0);
    setup(1, 0, 1, 2, 1);
    v0 = validCnt[1];
    sigIn[1] = 1; sigIn[2] = 1; cyc(4);
    sigIn[1] = 0; sigIn[0] = 1; cyc(1);
    sigIn[2] = 0; sigIn[0] = 0; cyc(5);
    sigIn[1] = 1; sigIn[0] = 1; cyc(4);
    sigIn[2] = 1; cyc(6);
    chk("R11 ch0", lastVal[0], 10);
    chk("R11 ch1", lastVal[1], 7);
    chk("R11 ch1 count", validCnt[1] - v0, 1);
    en = '0;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    t_reset();
    t_oneshot();
    t_prescale();
    t_falling();
    t_continuous();
    t_abort();
    t_saturate();
    t_indep();
    cyc(5);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule